// File: doc/BRIEF.md
# Dual-Path Programmable Phase Comparator

This block produces the error signal for an external phase-locked loop. The loop keeps a locally generated audio sample clock in step with a reference clock whose rate follows the incoming data rate. Two local oscillator signals enter the block. One belongs to the 44.1 kHz family and is divided by 147. The other belongs to the 48 kHz family and is divided by 160. Both prescaled outputs run at 153.6 kHz. A family-select bit picks one of them. The chosen signal then passes through a programmable divider, giving the local comparison wave SIG. The reference input passes through two dividers in series, giving REF.

A detector compares SIG with REF and drives a pad model made of a data bit and an output enable. It works in one of two styles. The XOR style always drives the pad. The edge style drives the pad only between the rising edges of SIG and REF and releases it at all other times. All configuration inputs are captured only while a reset is active. Configuration changes made during operation wait until the next reset. Every input is sampled in the single system clock domain.

Top module: `pcmp_top`

## Requirements
- R1: While rst_n is low, and on the cycle after soft_rst is high, pd_oe and pd_data are both 0.
- R2: cfg_fam_sel=1 routes loc_a_clk through a divide-by-147 prescaler and cfg_fam_sel=0 routes loc_b_clk through a divide-by-160 prescaler. The chosen prescaled wave is divided by 8*(cfg_k_m1+1), and the result is SIG. SIG rises on every 8*(cfg_k_m1+1)-th prescaled rising edge and is high for half of each period.
- R3: REF is ref_clk divided by N2 and then by N3. N2 is selected by cfg_n2_code: 00=5, 01=25, 10=125, 11=625. N3 equals cfg_n3_m1+1. For N3>1, REF is high for ceil(N3/2) of every N3 periods of the N2 output. For N3=1, REF is the N2 output, which is high for ceil(N2/2) reference periods.
- R4: With cfg_xor_mode=1, pd_oe is 1 at all times after reset, and pd_data equals SIG XOR REF, taken with equal latency on both paths.
- R5: With cfg_xor_mode=0 and cfg_reverse=0, when the REF rising edge leads the SIG rising edge by d cycles, pd_oe is 1 for d cycles per period with pd_data=1.
- R6: With cfg_xor_mode=0 and cfg_reverse=0, when REF trails SIG by d cycles, pd_oe is 1 for d cycles per period with pd_data=0.
- R7: cfg_reverse=1 swaps the pd_data polarity of the edge-mode lead and lag windows. In XOR mode cfg_reverse has no effect.
- R8: In edge mode, when the SIG and REF rising edges coincide, pd_oe stays 0.
- R9: Configuration inputs are captured only while rst_n is low or soft_rst is high. Changes made at other times have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; captures configuration |
| soft_rst | input | 1 | Synchronous soft reset, active high; captures configuration |
| loc_a_clk | input | 1 | Local 44.1 kHz-family oscillator signal (divide by 147) |
| loc_b_clk | input | 1 | Local 48 kHz-family oscillator signal (divide by 160) |
| ref_clk | input | 1 | Data-rate reference clock |
| cfg_fam_sel | input | 1 | 1 selects loc_a_clk, 0 selects loc_b_clk |
| cfg_k_m1 | input | K_W | Local divider multiple minus one (ratio 8*(value+1)) |
| cfg_n2_code | input | 2 | Reference prescaler code: 5, 25, 125 or 625 |
| cfg_n3_m1 | input | N3_W | Reference divider ratio minus one |
| cfg_xor_mode | input | 1 | 1 selects the XOR detector, 0 the edge detector |
| cfg_reverse | input | 1 | Swaps the edge-mode drive polarity |
| pd_data | output | 1 | Detector output data bit |
| pd_oe | output | 1 | Detector drive enable (0 means high impedance) |

## Verification
The hardest condition to reach is a known, stable phase offset at the detector. Each side passes through two divider stages with ratios in the hundreds or thousands, so the offset depends on when the first rising edge arrives on each input. The bench settles this with arithmetic. It starts the local wave at a fixed cycle and starts the reference wave at a chosen cycle r0. The SIG rising edge then lands at n*P - Pl + 1 and the REF rising edge at n*P - Pr + r0, where P is the period, Pl is the local input period and Pr is the reference input period. Choosing r0 therefore sets the lead or lag to an exact number of cycles. The bench then counts driven-high, driven-low and released cycles over one full period once the loop has settled.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_UP   = 2'd1,
        DET_DN   = 2'd2
    } det_state_e;

    // Reference prescaler ratio: 5 raised to (code + 1)
    function automatic int unsigned n2_value(input logic [1:0] code);
        int unsigned v;
        v = 5;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(code)) v = v * 5;
        end
        return v;
    endfunction

endpackage

// File: rtl/pcmp_div.sv
// Edge-counting divider. The output is high for the first ceil(N/2) input
// periods after every N-th input rising edge. A ratio of 0 or 1 passes the
// registered input through, so every stage adds the same one cycle of latency.
module pcmp_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_wave,
    input  logic [W-1:0] ratio,
    output logic         out_wave
);

    typedef struct packed {
        logic         in_q;
        logic [W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W-1:0] half;
    logic         multi;

    always_comb begin
        multi = (ratio > W'(1));
        half  = (ratio >> 1) + W'(ratio[0]);
        st_d      = st_q;
        st_d.in_q = in_wave;
        if (multi && in_wave && !st_q.in_q) begin
            if (st_q.cnt >= ratio - W'(1)) st_d.cnt = '0;
            else                           st_d.cnt = st_q.cnt + W'(1);
        end
        out_wave = multi ? (st_q.cnt < half) : st_q.in_q;
    end

    // in_q resets high so a level that is already high is not counted as an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.in_q <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcmp_det.sv
module pcmp_det
    import pcmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic ref_in,
    input  logic xor_mode,
    input  logic reverse,
    output logic pd_data,
    output logic pd_oe
);

    typedef struct packed {
        logic       sig_q;
        logic       ref_q;
        det_state_e state;
        logic       data;
        logic       oe;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    sig_rise;
    logic    ref_rise;

    always_comb begin
        sig_rise = sig && !st_q.sig_q;
        ref_rise = ref_in && !st_q.ref_q;
        st_d       = st_q;
        st_d.sig_q = sig;
        st_d.ref_q = ref_in;
        if (xor_mode) begin
            st_d.state = DET_IDLE;
            st_d.oe    = 1'b1;
            st_d.data  = sig ^ ref_in;
        end else begin
            case (st_q.state)
                DET_IDLE: begin
                    if (ref_rise && !sig_rise)      st_d.state = DET_UP;
                    else if (sig_rise && !ref_rise) st_d.state = DET_DN;
                end
                DET_UP:  if (sig_rise) st_d.state = DET_IDLE;
                DET_DN:  if (ref_rise) st_d.state = DET_IDLE;
                default: st_d.state = DET_IDLE;
            endcase
            st_d.oe   = (st_d.state != DET_IDLE);
            st_d.data = st_d.oe && ((st_d.state == DET_UP) ^ reverse);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sig_q <= 1'b1;
            st_q.ref_q <= 1'b1;
            st_q.state <= DET_IDLE;
            st_q.data  <= 1'b0;
            st_q.oe    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_data = st_q.data;
    assign pd_oe   = st_q.oe;

endmodule

// File: rtl/pcmp_top.sv
module pcmp_top
    import pcmp_pkg::*;
#(
    parameter int LOC_A_DIV = 147,
    parameter int LOC_B_DIV = 160,
    parameter int N1_STEP   = 8,
    parameter int K_W       = 4,
    parameter int N3_W      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            loc_a_clk,
    input  logic            loc_b_clk,
    input  logic            ref_clk,
    input  logic            cfg_fam_sel,
    input  logic [K_W-1:0]  cfg_k_m1,
    input  logic [1:0]      cfg_n2_code,
    input  logic [N3_W-1:0] cfg_n3_m1,
    input  logic            cfg_xor_mode,
    input  logic            cfg_reverse,
    output logic            pd_data,
    output logic            pd_oe
);

    localparam int PRE_MAX = (LOC_A_DIV > LOC_B_DIV) ? LOC_A_DIV : LOC_B_DIV;
    localparam int PRE_W   = $clog2(PRE_MAX + 1);
    localparam int N1_W    = $clog2(N1_STEP * (1 << K_W) + 1);
    localparam int N2_MAX  = int'(n2_value(2'b11));
    localparam int N2_W    = $clog2(N2_MAX + 1);
    localparam int N3C_W   = N3_W + 1;
    localparam int PRE_RATIO [2] = '{LOC_B_DIV, LOC_A_DIV};

    typedef struct packed {
        logic            fam_sel;
        logic [K_W-1:0]  k_m1;
        logic [1:0]      n2_code;
        logic [N3_W-1:0] n3_m1;
        logic            xor_mode;
        logic            reverse;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    cfg_t             cfg_d, cfg_q;
    logic             rst;
    logic [1:0]       pre_in;
    logic [1:0]       pre_wave;
    logic             pre_sel;
    logic [N1_W-1:0]  sig_ratio;
    logic [N2_W-1:0]  n2_ratio;
    logic [N3C_W-1:0] n3_ratio;
    logic             n2_wave;
    logic             sig_wave;
    logic             ref_wave;
    logic [CFG_W-1:0] cfg_bits;

    assign rst = !rst_n || soft_rst;

    // Configuration is loaded only during a reset
    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            cfg_d.fam_sel  = cfg_fam_sel;
            cfg_d.k_m1     = cfg_k_m1;
            cfg_d.n2_code  = cfg_n2_code;
            cfg_d.n3_m1    = cfg_n3_m1;
            cfg_d.xor_mode = cfg_xor_mode;
            cfg_d.reverse  = cfg_reverse;
        end
        sig_ratio = N1_W'((int'(cfg_q.k_m1) + 1) * N1_STEP);
        n2_ratio  = N2_W'(n2_value(cfg_q.n2_code));
        n3_ratio  = N3C_W'(int'(cfg_q.n3_m1) + 1);
        pre_sel   = pre_wave[cfg_q.fam_sel];
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_bits = cfg_q;
    assign pre_in   = {loc_a_clk, loc_b_clk};

    // Fixed prescalers, one per sample-rate family
    for (genvar g = 0; g < 2; g++) begin : g_pre
        pcmp_div #(.W(PRE_W)) u_pre (
            .clk      (clk),
            .rst      (rst),
            .in_wave  (pre_in[g]),
            .ratio    (PRE_W'(PRE_RATIO[g])),
            .out_wave (pre_wave[g])
        );
    end

    pcmp_div #(.W(N1_W)) u_n1 (
        .clk      (clk),
        .rst      (rst),
        .in_wave  (pre_sel),
        .ratio    (sig_ratio),
        .out_wave (sig_wave)
    );

    pcmp_div #(.W(N2_W)) u_n2 (
        .clk      (clk),
        .rst      (rst),
        .in_wave  (ref_clk),
        .ratio    (n2_ratio),
        .out_wave (n2_wave)
    );

    pcmp_div #(.W(N3C_W)) u_n3 (
        .clk      (clk),
        .rst      (rst),
        .in_wave  (n2_wave),
        .ratio    (n3_ratio),
        .out_wave (ref_wave)
    );

    pcmp_det u_det (
        .clk      (clk),
        .rst      (rst),
        .sig      (sig_wave),
        .ref_in   (ref_wave),
        .xor_mode (cfg_q.xor_mode),
        .reverse  (cfg_q.reverse),
        .pd_data  (pd_data),
        .pd_oe    (pd_oe)
    );

endmodule

// File: rtl/pcmp_chk.sv
module pcmp_chk #(
    parameter int CFG_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             xor_mode,
    input logic             pd_oe,
    input logic             pd_data,
    input logic             sig_wave,
    input logic             ref_wave,
    input logic [CFG_W-1:0] cfg_bits
);

    // R1: a soft reset leaves the pad released with data low
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (!pd_oe && !pd_data));

    // R4: XOR style always drives the pad
    assert_xor_driven_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (xor_mode && $past(rst_n) && !$past(soft_rst)) |-> pd_oe);

    // R5: a drive window in edge style opens only after a SIG or REF transition
    assert_window_follows_edge_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!xor_mode && $rose(pd_oe) && $past(rst_n, 2) && !$past(soft_rst, 2))
        |-> (($past(sig_wave) != $past(sig_wave, 2)) || ($past(ref_wave) != $past(ref_wave, 2))));

    // R6: the drive polarity stays fixed for the whole of a window
    assert_window_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!xor_mode && pd_oe && $past(pd_oe) && $past(rst_n) && !$past(soft_rst))
        |-> $stable(pd_data));

    // R9: captured configuration holds while no reset is active
    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        ($past(rst_n) && !$past(soft_rst)) |-> $stable(cfg_bits));

endmodule

bind pcmp_top pcmp_chk #(.CFG_W(CFG_W)) u_pcmp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .xor_mode (cfg_q.xor_mode),
    .pd_oe    (pd_oe),
    .pd_data  (pd_data),
    .sig_wave (sig_wave),
    .ref_wave (ref_wave),
    .cfg_bits (cfg_bits)
);

// File: tb/tb_pcmp_top.sv
`timescale 1ns/1ps
module tb_pcmp_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       loc_a_clk = 1'b0;
    logic       loc_b_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       cfg_fam_sel = 1'b0;
    logic [3:0] cfg_k_m1 = '0;
    logic [1:0] cfg_n2_code = '0;
    logic [4:0] cfg_n3_m1 = '0;
    logic       cfg_xor_mode = 1'b0;
    logic       cfg_reverse = 1'b0;
    logic       pd_data;
    logic       pd_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_hi, cnt_lo, cnt_z;
    int cyc = 0;

    always #2 clk = ~clk;

    pcmp_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .loc_a_clk    (loc_a_clk),
        .loc_b_clk    (loc_b_clk),
        .ref_clk      (ref_clk),
        .cfg_fam_sel  (cfg_fam_sel),
        .cfg_k_m1     (cfg_k_m1),
        .cfg_n2_code  (cfg_n2_code),
        .cfg_n3_m1    (cfg_n3_m1),
        .cfg_xor_mode (cfg_xor_mode),
        .cfg_reverse  (cfg_reverse),
        .pd_data      (pd_data),
        .pd_oe        (pd_oe)
    );

    typedef struct packed {
        logic        sel;
        logic [3:0]  km1;
        logic [1:0]  n2c;
        logic [4:0]  n3m1;
        logic        xm;
        logic        rv;
        logic [15:0] pl;
        logic [15:0] pr;
        logic [15:0] r0;
        logic [15:0] p;
    } vec_t;

    // Offset dd = r0 - pr - 1 + pl: negative means REF leads, positive means REF trails
    localparam vec_t VECS [10] = '{
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b0, 1'b0, 16'd2,  16'd16,  16'd5,   16'd2560},
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b0, 1'b0, 16'd2,  16'd16,  16'd40,  16'd2560},
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b0, 1'b0, 16'd2,  16'd16,  16'd15,  16'd2560},
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b0, 1'b1, 16'd2,  16'd16,  16'd5,   16'd2560},
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b1, 1'b0, 16'd2,  16'd16,  16'd40,  16'd2560},
        '{1'b0, 4'd0, 2'd0, 5'd31, 1'b1, 1'b1, 16'd2,  16'd16,  16'd40,  16'd2560},
        '{1'b1, 4'd0, 2'd0, 5'd20, 1'b0, 1'b0, 16'd10, 16'd112, 16'd100, 16'd11760},
        '{1'b1, 4'd0, 2'd0, 5'd20, 1'b1, 1'b0, 16'd10, 16'd112, 16'd120, 16'd11760},
        '{1'b0, 4'd1, 2'd0, 5'd31, 1'b0, 1'b0, 16'd2,  16'd32,  16'd20,  16'd5120},
        '{1'b0, 4'd4, 2'd1, 5'd0,  1'b1, 1'b0, 16'd2,  16'd512, 16'd500, 16'd12800}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5";
            1: return "R6";
            2: return "R8";
            3: return "R7";
            4: return "R4";
            5: return "R7";
            6: return "R2";
            7: return "R3";
            8: return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Number of cycles per period in which SIG and REF differ
    function automatic int xor_model(input int p, input int dd, input int h);
        int n = 0;
        for (int t = 0; t < p; t++) begin
            bit a, b;
            a = (t < p / 2);
            b = ((((t - dd) % p) + p) % p) < h;
            if (a != b) n++;
        end
        return n;
    endfunction

    task automatic run_vec(input vec_t v, input bit mid_change);
        int settle;
        settle = (int'(v.p) * 5) / 4;
        cnt_hi = 0; cnt_lo = 0; cnt_z = 0;
        @(negedge clk);
        cfg_fam_sel = v.sel; cfg_k_m1 = v.km1; cfg_n2_code = v.n2c;
        cfg_n3_m1 = v.n3m1; cfg_xor_mode = v.xm; cfg_reverse = v.rv;
        rst_n = 1'b0; loc_a_clk = 1'b0; loc_b_clk = 1'b0; ref_clk = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < settle + int'(v.p); t++) begin
            logic lw, rw;
            lw = (t >= 1) && (((t - 1) % int'(v.pl)) < int'(v.pl) / 2);
            rw = (t >= int'(v.r0)) && (((t - int'(v.r0)) % int'(v.pr)) < int'(v.pr) / 2);
            if (v.sel) begin
                loc_a_clk = lw; loc_b_clk = t[1];
            end else begin
                loc_b_clk = lw; loc_a_clk = t[1];
            end
            ref_clk = rw;
            if (mid_change && t == 100) begin
                // R9: these inputs must be ignored outside reset
                cfg_xor_mode = 1'b1; cfg_reverse = ~v.rv; cfg_fam_sel = ~v.sel;
                cfg_k_m1 = 4'd3; cfg_n2_code = 2'd3; cfg_n3_m1 = 5'd0;
            end
            if (t >= settle) begin
                if (!pd_oe)       cnt_z++;
                else if (pd_data) cnt_hi++;
                else              cnt_lo++;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_counts(input vec_t v, input string tag);
        int dd, ad, n2, n3, h, p, xc;
        p  = int'(v.p);
        dd = int'(v.r0) - int'(v.pr) - 1 + int'(v.pl);
        ad = (dd < 0) ? -dd : dd;
        n2 = 5;
        for (int i = 0; i < int'(v.n2c); i++) n2 = n2 * 5;
        n3 = int'(v.n3m1) + 1;
        h  = (n3 > 1) ? ((n3 + 1) / 2) * n2 * int'(v.pr) : ((n2 + 1) / 2) * int'(v.pr);
        if (v.xm) begin
            xc = xor_model(p, dd, h);
            check(tag, "xor high cycles", cnt_hi, xc);
            check(tag, "xor low cycles", cnt_lo, p - xc);
            check(tag, "xor released cycles", cnt_z, 0);
        end else begin
            // REF lead drives high, REF lag drives low; reverse swaps them
            check(tag, "edge high cycles", cnt_hi, ((dd < 0) != v.rv) ? ad : 0);
            check(tag, "edge low cycles", cnt_lo, ((dd < 0) != v.rv) ? 0 : ad);
            check(tag, "edge released cycles", cnt_z, p - ad);
        end
    endtask

    initial begin
        while (cyc < 195000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet while the synchronous reset is held
        repeat (3) @(negedge clk);
        check("R1", "oe during reset", int'(pd_oe), 0);
        check("R1", "data during reset", int'(pd_data), 0);

        // Table walk over configurations and phase offsets
        for (int i = 0; i < 10; i++) begin
            run_vec(VECS[i], 1'b0);
            expect_counts(VECS[i], vec_tag(i));
        end

        // R1: soft reset after an XOR run releases the pad on the next cycle
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R1", "oe after soft reset", int'(pd_oe), 0);
        check("R1", "data after soft reset", int'(pd_data), 0);

        // R9: configuration changed mid-run has no effect (expect table entry 0)
        run_vec(VECS[0], 1'b1);
        expect_counts(VECS[0], "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule